// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss without software help. A requester gives it a 20-bit virtual page number and an access kind. The walker adds the page number, scaled by the 4-byte entry size, to a base register that holds the physical start of the current single-level page table. It then issues one read on a simple request/response memory port.

When the entry returns, the walker decodes its valid bit, its 2-bit access-rights field and its physical page number. It produces exactly one completion pulse. The pulse carries one of three outcomes: a translation, a page fault, or a protection violation.

Software loads the base register through a write strobe on a context switch. The walker takes one request at a time and is idle again two cycles after the memory response.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, mem_req_o is 0, done_o is 0, page_fault_o and prot_fault_o are 0, and the table base is 0.
- R2: base_we_i high at a clock edge loads base_i into the table base. The cycle after a request is accepted, mem_addr_o equals the table base plus the virtual page number shifted left by 2 (4-byte entries), computed modulo 2^32.
- R3: A request is taken only when req_ready_o is 1, which holds only while idle. A req_valid_i raised while a walk is in flight is ignored: it causes no new read and no extra completion.
- R4: From acceptance until mem_rvalid_i is seen, mem_req_o stays 1 and mem_addr_o stays unchanged.
- R5: Each accepted request yields exactly one done_o pulse, one cycle long, in the cycle after the response edge. req_ready_o returns the cycle after that.
- R6: The entry layout is: bit 31 valid, bits 30:29 rights, bits 28:0 physical page number. On a permitted access, ppn_o carries bits 28:0 with both fault flags at 0.
- R7: An entry with bit 31 at 0 gives page_fault_o=1, prot_fault_o=0 and ppn_o=0, whatever its rights field holds.
- R8: The rights encoding is 00 none, 01 read-only, 10 read/write and 11 execute. The access kinds are 00 load, 01 store, 10 fetch, and 11, which is treated as a load. A store needs 10, a fetch needs 11, and a load needs 01 or 10. Any other pairing gives prot_fault_o=1 and ppn_o=0.
- R9: A mem_rvalid_i that arrives while no read is outstanding is ignored: done_o stays 0 and req_ready_o stays 1.
- R10: Outside a done_o pulse, ppn_o, page_fault_o and prot_fault_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load strobe for the table base |
| base_i | input | 32 | New table base (physical byte address) |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| req_vpn_i | input | 20 | Virtual page number to translate |
| req_kind_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| mem_req_o | output | 1 | Entry read outstanding |
| mem_addr_o | output | 32 | Entry byte address |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 32 | Entry read data |
| done_o | output | 1 | Walk complete, one-cycle pulse |
| ppn_o | output | 29 | Physical page number on success, else 0 |
| page_fault_o | output | 1 | Entry not valid |
| prot_fault_o | output | 1 | Access kind not permitted by rights |

## Verification
The assertions assume that the memory raises mem_rvalid_i only for a read the walker has issued. They also assume that mem_rvalid_i lasts one cycle per read, and that req_valid_i is driven low during reset. The scoreboard driver keeps to this. It raises mem_rvalid_i for exactly one cycle after a chosen latency of zero or more cycles, with the entry on mem_rdata_i. The only stray response it sends comes during idle, to exercise the ignore rule. Stray requests during a walk are driven on purpose, since the walker must drop them itself.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    RGT_NONE = 2'b00,
    RGT_RO   = 2'b01,
    RGT_RW   = 2'b10,
    RGT_EXEC = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_DONE = 2'b10
  } walk_st_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PA_W        = 32,
  parameter int unsigned ENTRY_BYTES = 4
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic [PA_W-1:0] offset;

  always_comb begin
    offset = PA_W'(vpn_i) << SHIFT;
    addr_o = base_i + offset;
  end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       kind_i,
  output logic [PTE_W-4:0] ppn_o,
  output logic             page_fault_o,
  output logic             prot_fault_o
);
  localparam int unsigned VALID_BIT = PTE_W - 1;
  localparam int unsigned RGT_LSB   = PTE_W - 3;

  logic    valid;
  rights_e rights;
  logic    allowed;

  always_comb begin
    valid  = pte_i[VALID_BIT];
    rights = rights_e'(pte_i[RGT_LSB +: 2]);
    unique case (acc_kind_e'(kind_i))
      ACC_STORE: allowed = (rights == RGT_RW);
      ACC_FETCH: allowed = (rights == RGT_EXEC);
      default:   allowed = (rights == RGT_RO) || (rights == RGT_RW);
    endcase
    // invalid entry wins over any rights mismatch
    page_fault_o = !valid;
    prot_fault_o = valid && !allowed;
    ppn_o        = (valid && allowed) ? pte_i[PTE_W-4:0] : '0;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PPN_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic [PA_W-1:0]  addr_next_i,
  output logic [1:0]       kind_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PPN_W-1:0] chk_ppn_i,
  input  logic             chk_pf_i,
  input  logic             chk_pv_i,
  output logic             done_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             page_fault_o,
  output logic             prot_fault_o
);
  walk_st_e         st_q;
  logic [PA_W-1:0]  addr_q;
  logic [1:0]       kind_q;
  logic             done_q, pf_q, pv_q;
  logic [PPN_W-1:0] ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      kind_q <= ACC_LOAD;
      done_q <= 1'b0;
      ppn_q  <= '0;
      pf_q   <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ppn_q  <= '0;
      pf_q   <= 1'b0;
      pv_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q   <= ST_WAIT;
          addr_q <= addr_next_i;
          kind_q <= req_kind_i;
        end
        ST_WAIT: if (mem_rvalid_i) begin
          st_q   <= ST_DONE;
          done_q <= 1'b1;
          ppn_q  <= chk_ppn_i;
          pf_q   <= chk_pf_i;
          pv_q   <= chk_pv_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_WAIT);
  assign mem_addr_o   = addr_q;
  assign kind_o       = kind_q;
  assign done_o       = done_q;
  assign ppn_o        = ppn_q;
  assign page_fault_o = pf_q;
  assign prot_fault_o = pv_q;

  p_busy_not_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  p_hold_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_single_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_follows_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_rvalid_i));
  p_ready_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);
  p_pf_no_ppn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_o |-> (!prot_fault_o && ppn_o == '0));
  p_pv_no_ppn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> (ppn_o == '0));
  p_idle_rsp_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i && mem_rvalid_i) |=> (!done_o && req_ready_o));
  p_quiet_outputs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!page_fault_o && !prot_fault_o && ppn_o == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W        = 32,
  parameter int unsigned PAGE_W      = 12,
  parameter int unsigned PA_W        = 32,
  parameter int unsigned PTE_W       = 32,
  parameter int unsigned ENTRY_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    base_we_i,
  input  logic [PA_W-1:0]         base_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [VA_W-PAGE_W-1:0]  req_vpn_i,
  input  logic [1:0]              req_kind_i,
  output logic                    mem_req_o,
  output logic [PA_W-1:0]         mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [PTE_W-1:0]        mem_rdata_i,
  output logic                    done_o,
  output logic [PTE_W-4:0]        ppn_o,
  output logic                    page_fault_o,
  output logic                    prot_fault_o
);
  localparam int unsigned VPN_W = VA_W - PAGE_W;
  localparam int unsigned PPN_W = PTE_W - 3;
  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  addr_next;
  logic [1:0]       kind_q;
  logic [PPN_W-1:0] chk_ppn;
  logic             chk_pf, chk_pv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  pt_addr_gen #(
    .VPN_W(VPN_W), .PA_W(PA_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) i_addr_gen (
    .base_i(base_q), .vpn_i(req_vpn_i), .addr_o(addr_next)
  );

  pt_entry_check #(.PTE_W(PTE_W)) i_entry_check (
    .pte_i(mem_rdata_i), .kind_i(kind_q),
    .ppn_o(chk_ppn), .page_fault_o(chk_pf), .prot_fault_o(chk_pv)
  );

  pt_walk_fsm #(.PA_W(PA_W), .PPN_W(PPN_W)) i_walk_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_kind_i,
    .addr_next_i(addr_next), .kind_o(kind_q),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i,
    .chk_ppn_i(chk_ppn), .chk_pf_i(chk_pf), .chk_pv_i(chk_pv),
    .done_o, .ppn_o, .page_fault_o, .prot_fault_o
  );

  p_addr_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |->
      (mem_addr_o == $past(base_q) + (PA_W'($past(req_vpn_i)) << SHIFT)));
  p_no_early_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && !mem_rvalid_i) |=> !done_o);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  typedef struct packed {
    logic [28:0] ppn;
    logic        pf;
    logic        pv;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [19:0] req_vpn_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o;
  logic [28:0] ppn_o;
  logic        page_fault_o, prot_fault_o;

  int vectors = 0;
  int misses  = 0;
  int pushed  = 0;
  int seen    = 0;
  logic [31:0] base_model = '0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk_i(clk), .rst_ni, .base_we_i, .base_i,
    .req_valid_i, .req_ready_o, .req_vpn_i, .req_kind_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .done_o, .ppn_o, .page_fault_o, .prot_fault_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kinds: 00 load, 01 store, 10 fetch, 11 load; rights: 00 none 01 ro 10 rw 11 exec
  function automatic exp_t model(input logic [31:0] pte, input logic [1:0] kind);
    exp_t e;
    logic ok;
    case (kind)
      2'b01:   ok = (pte[30:29] == 2'b10);
      2'b10:   ok = (pte[30:29] == 2'b11);
      default: ok = (pte[30:29] == 2'b01) || (pte[30:29] == 2'b10);
    endcase
    e.pf  = !pte[31];
    e.pv  = pte[31] && !ok;
    e.ppn = (pte[31] && ok) ? pte[28:0] : '0;
    return e;
  endfunction

  function automatic logic [31:0] mk(input logic v, input logic [1:0] r, input logic [28:0] p);
    return {v, r, p};
  endfunction

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we_i = 1'b1;
    base_i = b;
    @(negedge clk);
    base_we_i = 1'b0;
    base_model = b;
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [1:0] kind,
                      input logic [31:0] pte, input int lat, input bit stray,
                      input string tag);
    logic [31:0] ea;
    ea = base_model + {10'd0, vpn, 2'b00};
    sb_q.push_back(model(pte, kind));
    pushed++;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R3", "ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1;
    req_vpn_i = vpn;
    req_kind_i = kind;
    @(negedge clk);
    req_valid_i = stray;
    req_vpn_i = ~vpn;
    req_kind_i = ~kind;
    chk(mem_req_o == 1'b1, "R4", {tag, " mem_req raised"}, 64'(mem_req_o), 64'd1);
    chk(mem_addr_o == ea, "R2", {tag, " entry address"}, 64'(mem_addr_o), 64'(ea));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_req_o && mem_addr_o == ea, "R4", {tag, " address held"},
          64'(mem_addr_o), 64'(ea));
      if (stray)
        chk(req_ready_o == 1'b0, "R3", {tag, " busy not ready"}, 64'(req_ready_o), 64'd0);
    end
    mem_rvalid_i = 1'b1;
    mem_rdata_i = pte;
    req_valid_i = 1'b0;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    mem_rdata_i = 32'hdead_beef;
  endtask

  // scoreboard monitor
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o && done_prev)
        chk(1'b0, "R5", "done longer than one cycle", 64'd2, 64'd1);
      if (done_o) begin
        seen++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(ppn_o == e.ppn, "R6", "ppn", 64'(ppn_o), 64'(e.ppn));
          chk(page_fault_o == e.pf, "R7", "page fault", 64'(page_fault_o), 64'(e.pf));
          chk(prot_fault_o == e.pv, "R8", "protection", 64'(prot_fault_o), 64'(e.pv));
        end
      end else begin
        if (page_fault_o || prot_fault_o || ppn_o != '0)
          chk(1'b0, "R10", "outputs not quiet", 64'(ppn_o), 64'd0);
      end
    end
    done_prev = done_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 64'(req_ready_o), 64'd1);
    chk(mem_req_o == 1'b0, "R1", "mem_req in reset", 64'(mem_req_o), 64'd0);
    chk(done_o == 1'b0 && !page_fault_o && !prot_fault_o, "R1", "done/faults in reset",
        64'(done_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1 && mem_req_o == 1'b0, "R1", "idle after reset",
        64'(mem_req_o), 64'd0);

    // R2 base starts at 0; R6 translation
    walk(20'h00005, 2'b00, mk(1'b1, 2'b01, 29'h0000_123), 0, 1'b0, "R2 base0");
    set_base(32'h0010_0000);
    walk(20'hABCDE, 2'b01, mk(1'b1, 2'b10, 29'h1AB_CDEF), 3, 1'b1, "R3 stray");
    // R8 rights matrix
    walk(20'h00001, 2'b01, mk(1'b1, 2'b01, 29'h0000_001), 1, 1'b0, "R8 st-ro");
    walk(20'h00002, 2'b10, mk(1'b1, 2'b11, 29'h0000_0A2), 0, 1'b0, "R8 fe-ex");
    walk(20'h00003, 2'b10, mk(1'b1, 2'b10, 29'h0000_0A3), 2, 1'b0, "R8 fe-rw");
    walk(20'h00004, 2'b00, mk(1'b1, 2'b11, 29'h0000_0A4), 0, 1'b0, "R8 ld-ex");
    walk(20'h00006, 2'b00, mk(1'b1, 2'b00, 29'h0000_0A6), 0, 1'b0, "R8 ld-none");
    walk(20'h00007, 2'b01, mk(1'b1, 2'b00, 29'h0000_0A7), 0, 1'b0, "R8 st-none");
    walk(20'h00008, 2'b11, mk(1'b1, 2'b01, 29'h0000_0A8), 0, 1'b0, "R8 rsvd-ro");
    walk(20'h00009, 2'b00, mk(1'b1, 2'b10, 29'h1FFF_FFFF), 0, 1'b0, "R6 ld-rw max");
    // R7 invalid wins over rights
    walk(20'h0000A, 2'b01, mk(1'b0, 2'b10, 29'h0000_0AA), 0, 1'b0, "R7 inv-st");
    walk(20'h0000B, 2'b10, mk(1'b0, 2'b00, 29'h0000_0AB), 4, 1'b1, "R7 inv-fe");
    // R2 wrap at top of table
    set_base(32'h8000_0000);
    walk(20'hFFFFF, 2'b00, mk(1'b1, 2'b01, 29'h0ABC_DEF), 0, 1'b0, "R2 top vpn");
    set_base(32'hFFFF_FFF0);
    walk(20'h00008, 2'b10, mk(1'b1, 2'b11, 29'h0000_777), 0, 1'b0, "R2 wrap");

    // R9 stray response while idle
    @(negedge clk);
    mem_rvalid_i = 1'b1;
    mem_rdata_i = mk(1'b1, 2'b10, 29'h0000_555);
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    chk(done_o == 1'b0, "R9", "no done from idle response", 64'(done_o), 64'd0);
    chk(req_ready_o == 1'b1, "R9", "still ready", 64'(req_ready_o), 64'd1);
    @(negedge clk);
    chk(done_o == 1'b0 && mem_req_o == 1'b0, "R9", "no walk started", 64'(mem_req_o), 64'd0);

    repeat (3) @(negedge clk);
    chk(seen == pushed, "R5", "one done per request", 64'(seen), 64'(pushed));
    chk(sb_q.size() == 0, "R5", "scoreboard drained", 64'(sb_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule